// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Override

This block is a parameterized bidirectional digital I/O port. Each pin has a direction bit and an output bit held in registers, a pull-up that follows from those two bits, and an input path that brings the pad level into the clock domain through a falling-edge stage followed by a rising-edge stage. Software updates the registers through a small access port. A write either replaces a whole register or sets or clears one bit, and a single-bit operation leaves every other pin untouched.

Peripherals such as a serial master/slave link, a UART or a two-wire bus can take control of a pin. Each pin has four enable/value pairs, one for pull-up, one for direction, one for output value and one for digital-input enable. While an enable bit is high, its value bit drives the pad signal in place of the register-derived one. A port-wide pull-up disable removes every register-derived pull-up. When the digital input of a pin is disabled, for example during sleep, the value fed to the synchronizer is held at 0.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output registers are 0, so `pad_oe`, `pad_do` and `pad_pu` are all 0 and `rd_dir`/`rd_out` read 0.
- R2: An access with `acc_op` = 0 (write) loads `acc_wdata` into the register chosen by `acc_sel` (0 = direction, 1 = output). The value shows on `rd_dir`/`rd_out` after that rising edge.
- R3: An access with `acc_op` = 1 (set) drives bit `acc_bit` of the chosen register to 1 and leaves all other bits of both registers unchanged.
- R4: An access with `acc_op` = 2 (clear) drives bit `acc_bit` of the chosen register to 0 and leaves all other bits of both registers unchanged.
- R5: With no override active, `pad_oe` equals the direction register, `pad_do` equals the output register, and `pad_pu[i]` is 1 exactly when direction bit i is 0 and output bit i is 1.
- R6: While `pu_off` is 1, `pad_pu` is 0 on every pin whose pull-up override enable is 0, whatever the register contents.
- R7: For each pin, when `ov_pu_en[i]`, `ov_dir_en[i]` or `ov_out_en[i]` is 1, the matching pad signal takes the paired `ov_*_val[i]` bit. This also applies when a peripheral forces a pin to input while its direction bit is 1.
- R8: A pad level applied just after a rising edge is not yet on `pin_in` after the following falling edge, and it appears on `pin_in` after the next rising edge.
- R9: The digital-input enable of pin i is `ov_die_val[i]` when `ov_die_en[i]` is 1, and otherwise the inverse of `sleep`. While the enable is 0, `pin_in[i]` reads 0 within two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_sel | input | 1 | Target register: 0 direction, 1 output |
| acc_op | input | 2 | 0 write, 1 set bit, 2 clear bit |
| acc_bit | input | IDXW | Bit index for set/clear |
| acc_wdata | input | WIDTH | Data for a full write |
| rd_dir | output | WIDTH | Direction register readback |
| rd_out | output | WIDTH | Output register readback |
| pu_off | input | 1 | Port-wide pull-up disable |
| sleep | input | 1 | Disables digital inputs unless overridden |
| ov_pu_en | input | WIDTH | Pull-up override enable |
| ov_pu_val | input | WIDTH | Pull-up override value |
| ov_dir_en | input | WIDTH | Direction override enable |
| ov_dir_val | input | WIDTH | Direction override value |
| ov_out_en | input | WIDTH | Output-value override enable |
| ov_out_val | input | WIDTH | Output-value override value |
| ov_die_en | input | WIDTH | Digital-input-enable override enable |
| ov_die_val | input | WIDTH | Digital-input-enable override value |
| pad_in | input | WIDTH | Pad level seen by the port |
| pad_oe | output | WIDTH | Pad driver enable |
| pad_do | output | WIDTH | Pad drive value |
| pad_pu | output | WIDTH | Pad pull-up enable |
| pin_in | output | WIDTH | Synchronized pin value |

## Verification
The bench builds the port with its default WIDTH of 8, which makes IDXW 3. At this width each bit pattern in the stimulus table can mix overridden and register-driven pins in the same byte. Single-bit set and clear can reach both the lowest and the highest pin, so the bench checks that the remaining pins stay as they were.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2
    } acc_op_e;

    typedef enum logic {
        TGT_DIR = 1'b0,
        TGT_OUT = 1'b1
    } acc_tgt_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_sel,
    input  logic [1:0]       acc_op,
    input  logic [IDXW-1:0]  acc_bit,
    input  logic [WIDTH-1:0] acc_wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] out;
    } regs_t;

    regs_t st_d, st_q;
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    always_comb begin
        st_d     = st_q;
        bit_mask = ONE << acc_bit;
        cur      = (acc_sel == TGT_OUT) ? st_q.out : st_q.dir;
        nxt      = cur;
        case (acc_op)
            OP_WRITE: nxt = acc_wdata;
            OP_SET:   nxt = cur | bit_mask;
            OP_CLR:   nxt = cur & ~bit_mask;
            default:  nxt = cur;
        endcase
        if (acc_valid) begin
            if (acc_sel == TGT_OUT) st_d.out = nxt;
            else                    st_d.dir = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;
    assign out_q = st_q.out;

    // R2: full write lands in the selected register
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == OP_WRITE && acc_sel == TGT_DIR)
        |=> (dir_q == $past(acc_wdata)));

    // R3: set touches only the chosen bit
    p_set_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == OP_SET && acc_sel == TGT_OUT)
        |=> (out_q[$past(acc_bit)] &&
             (((out_q ^ $past(out_q)) & ~(ONE << $past(acc_bit))) == '0) &&
             (dir_q == $past(dir_q))));

    // R4: clear touches only the chosen bit
    p_clr_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == OP_CLR && acc_sel == TGT_DIR)
        |=> (!dir_q[$past(acc_bit)] &&
             (((dir_q ^ $past(dir_q)) & ~(ONE << $past(acc_bit))) == '0) &&
             (out_q == $past(out_q))));
endmodule

// File: rtl/gpio_override.sv
module gpio_override #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    input  logic             pu_off,
    input  logic             sleep,
    input  logic [WIDTH-1:0] ov_pu_en,
    input  logic [WIDTH-1:0] ov_pu_val,
    input  logic [WIDTH-1:0] ov_dir_en,
    input  logic [WIDTH-1:0] ov_dir_val,
    input  logic [WIDTH-1:0] ov_out_en,
    input  logic [WIDTH-1:0] ov_out_val,
    input  logic [WIDTH-1:0] ov_die_en,
    input  logic [WIDTH-1:0] ov_die_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] die
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic pu_base;
        always_comb begin
            pu_base   = ~dir_q[i] & out_q[i] & ~pu_off;
            pad_pu[i] = ov_pu_en[i]  ? ov_pu_val[i]  : pu_base;
            pad_oe[i] = ov_dir_en[i] ? ov_dir_val[i] : dir_q[i];
            pad_do[i] = ov_out_en[i] ? ov_out_val[i] : out_q[i];
            die[i]    = ov_die_en[i] ? ov_die_val[i] : ~sleep;
        end
    end
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    input  logic [WIDTH-1:0] die_i,
    output logic [WIDTH-1:0] pin_o
);
    logic [WIDTH-1:0] half_d, half_q;
    logic [WIDTH-1:0] pin_d, pin_q;

    always_comb begin
        half_d = pad_i & die_i;
        pin_d  = half_q;
    end

    // falling-edge stage: plays the part of the transparent-low latch
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= half_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    // R9: a pin whose input is disabled across a full cycle reads 0
    p_die_forces_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~die_i & ~$past(die_i) & pin_q) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_sel,
    input  logic [1:0]       acc_op,
    input  logic [IDXW-1:0]  acc_bit,
    input  logic [WIDTH-1:0] acc_wdata,
    output logic [WIDTH-1:0] rd_dir,
    output logic [WIDTH-1:0] rd_out,
    input  logic             pu_off,
    input  logic             sleep,
    input  logic [WIDTH-1:0] ov_pu_en,
    input  logic [WIDTH-1:0] ov_pu_val,
    input  logic [WIDTH-1:0] ov_dir_en,
    input  logic [WIDTH-1:0] ov_dir_val,
    input  logic [WIDTH-1:0] ov_out_en,
    input  logic [WIDTH-1:0] ov_out_val,
    input  logic [WIDTH-1:0] ov_die_en,
    input  logic [WIDTH-1:0] ov_die_val,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pin_in
);
    logic [WIDTH-1:0] dir_q, out_q, die;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_sel(acc_sel), .acc_op(acc_op),
        .acc_bit(acc_bit), .acc_wdata(acc_wdata),
        .dir_q(dir_q), .out_q(out_q)
    );

    gpio_override #(.WIDTH(WIDTH)) u_ovr (
        .dir_q(dir_q), .out_q(out_q), .pu_off(pu_off), .sleep(sleep),
        .ov_pu_en(ov_pu_en), .ov_pu_val(ov_pu_val),
        .ov_dir_en(ov_dir_en), .ov_dir_val(ov_dir_val),
        .ov_out_en(ov_out_en), .ov_out_val(ov_out_val),
        .ov_die_en(ov_die_en), .ov_die_val(ov_die_val),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .die(die)
    );

    gpio_insync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_in), .die_i(die), .pin_o(pin_in)
    );

    assign rd_dir = dir_q;
    assign rd_out = out_q;

    // R6: port-wide disable removes every non-overridden pull-up
    p_pu_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pu_off |-> ((pad_pu & ~ov_pu_en) == '0));

    // R1: freshly reset registers leave the pads undriven
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((rd_dir == '0) && (rd_out == '0)));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int W = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_sel = 1'b0;
    logic [1:0] acc_op = 2'd0;
    logic [IW-1:0] acc_bit = '0;
    logic [W-1:0] acc_wdata = '0;
    logic [W-1:0] rd_dir, rd_out, pad_oe, pad_do, pad_pu, pin_in;
    logic pu_off = 1'b0, sleep = 1'b0;
    logic [W-1:0] ov_pu_en = '0, ov_pu_val = '0, ov_dir_en = '0, ov_dir_val = '0;
    logic [W-1:0] ov_out_en = '0, ov_out_val = '0, ov_die_en = '0, ov_die_val = '0;
    logic [W-1:0] pad_in = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_sel(acc_sel), .acc_op(acc_op),
        .acc_bit(acc_bit), .acc_wdata(acc_wdata),
        .rd_dir(rd_dir), .rd_out(rd_out),
        .pu_off(pu_off), .sleep(sleep),
        .ov_pu_en(ov_pu_en), .ov_pu_val(ov_pu_val),
        .ov_dir_en(ov_dir_en), .ov_dir_val(ov_dir_val),
        .ov_out_en(ov_out_en), .ov_out_val(ov_out_val),
        .ov_die_en(ov_die_en), .ov_die_val(ov_die_val),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
        .pad_pu(pad_pu), .pin_in(pin_in)
    );

    typedef struct packed {
        logic [7:0] dir, out;
        logic [7:0] puoff;
        logic [7:0] pue, puv, dire, dirv, oute, outv;
        logic [7:0] e_oe, e_do, e_pu;
    } vec_t;

    // stimulus -> expected pad signals (R2, R5, R6, R7)
    localparam vec_t TBL [6] = '{
        '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF},
        '{8'hF0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h3C, 8'h0C},
        '{8'hF0, 8'h3C, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h3C, 8'h00},
        '{8'hF0, 8'h3C, 8'h01, 8'h81, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h3C, 8'h01},
        '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h05, 8'hF0, 8'hA0, 8'hF5, 8'hA0, 8'h00},
        '{8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic sel, input logic [1:0] op,
                          input logic [IW-1:0] b, input logic [W-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_sel = sel; acc_op = op; acc_bit = b; acc_wdata = d;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 do", pad_do, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 dir", rd_dir, 8'h00);

        for (int k = 0; k < 6; k++) begin
            access(1'b0, 2'd0, '0, TBL[k].dir);
            access(1'b1, 2'd0, '0, TBL[k].out);
            check("R2 dir", rd_dir, TBL[k].dir);
            check("R2 out", rd_out, TBL[k].out);
            pu_off = TBL[k].puoff[0];
            ov_pu_en = TBL[k].pue;   ov_pu_val = TBL[k].puv;
            ov_dir_en = TBL[k].dire; ov_dir_val = TBL[k].dirv;
            ov_out_en = TBL[k].oute; ov_out_val = TBL[k].outv;
            #1;
            check("R7/R5 oe", pad_oe, TBL[k].e_oe);
            check("R7/R5 do", pad_do, TBL[k].e_do);
            check("R7/R6/R5 pu", pad_pu, TBL[k].e_pu);
        end
        pu_off = 1'b0;
        ov_pu_en = '0; ov_dir_en = '0; ov_out_en = '0;

        // R3: set single bits at both ends
        access(1'b0, 2'd0, '0, 8'h00);
        access(1'b1, 2'd0, '0, 8'h42);
        access(1'b1, 2'd1, 3'd7, '0);
        check("R3 out msb", rd_out, 8'hC2);
        access(1'b0, 2'd1, 3'd0, '0);
        check("R3 dir lsb", rd_dir, 8'h01);
        check("R3 out kept", rd_out, 8'hC2);

        // R4: clear single bits
        access(1'b0, 2'd0, '0, 8'hFF);
        access(1'b0, 2'd2, 3'd3, '0);
        check("R4 dir", rd_dir, 8'hF7);
        check("R4 out kept", rd_out, 8'hC2);
        access(1'b1, 2'd2, 3'd1, '0);
        check("R4 out", rd_out, 8'hC0);

        // R8: synchronizer latency
        @(posedge clk);
        #1;
        pad_in = 8'h5A;
        @(negedge clk);
        #1;
        check("R8 not yet", pin_in, 8'h00);
        @(posedge clk);
        #1;
        check("R8 arrived", pin_in, 8'h5A);

        // R9: sleep disables inputs, override re-enables some
        sleep = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R9 sleep", pin_in, 8'h00);
        ov_die_en = 8'hFF;
        ov_die_val = 8'h0F;
        repeat (2) @(posedge clk);
        #1;
        check("R9 override", pin_in, 8'h0A);
        sleep = 1'b0;
        ov_die_en = 8'h00;
        repeat (2) @(posedge clk);
        #1;
        check("R9 awake", pin_in, 8'h5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule